// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Command Master

This block is a serial master for a peripheral wired through three pins only: an active-low select, a clock, and a single data wire shared by both directions. A local requester presents one command at a time: register write, register read, transmit request, or masked bit update. The block frames the select line, shifts the command bytes out most significant bit first and, for a read, releases the shared wire and shifts one byte back in. It reports completion with a one-cycle pulse and returns read data.

The data wire appears on the port list as a drive value, a drive enable and a sampled input, so a pad cell outside the block makes the tri-state wire. Clock timing uses a "time unit" of `UNIT_CYCLES` core clocks. The low half of each serial clock has a fixed length. The high half is one unit longer when the bit on the wire is a one, so the serial rate depends on the data. Opcodes, phase lengths, input synchroniser depth and the width of the transmit-request selector are parameters.

Top module: `tw3_spi_master`

## Requirements
- R1: After reset and whenever no command is in progress, `spi_cs_n` is 1, `spi_sck` is 0, `spi_sdio_out` is 0, `spi_sdio_oe` is 1, `busy` and `done` are 0, and `rd_data` is 0 until the first read completes.
- R2: A command is accepted on a clock edge where `cmd_valid` is 1 and `busy` is 0. `busy` stays 1 from that edge until the edge on which `spi_cs_n` returns high. A `cmd_valid` raised while `busy` is 1 is ignored: it starts no frame and does not alter the bytes of the frame in progress.
- R3: Every byte goes out most significant bit first. The data wire changes only while `spi_sck` is low and holds its value while `spi_sck` is high, so the peripheral can sample on the rising edge.
- R4: Every clock-low interval inside a frame lasts `LOW_UNITS*UNIT_CYCLES` core cycles. This includes the lead from the fall of `spi_cs_n` to the first rising edge and the tail from the last falling edge to the rise of `spi_cs_n`.
- R5: A clock-high interval lasts `HIGH0_UNITS*UNIT_CYCLES` cycles when the bit on the wire is 0 and `HIGH1_UNITS*UNIT_CYCLES` cycles when it is 1. This holds for bits received during a read as well as bits sent.
- R6: `cmd_op`=0 (write) sends 0x02, then `cmd_addr`, then `cmd_wdata`, all in one select frame.
- R7: `cmd_op`=1 (read) sends 0x03 and then `cmd_addr`. After the falling edge that ends the address byte it drops `spi_sdio_oe` and samples 8 bits, most significant first, at the rising edges. The byte appears on `rd_data` with `done`. `spi_sdio_oe` returns to 1 only on the edge where `spi_cs_n` rises. Other commands leave `rd_data` unchanged.
- R8: `cmd_op`=2 (transmit request) sends a single byte, 0x80 OR `cmd_wdata[2:0]`. The upper bits of `cmd_wdata` are ignored.
- R9: `cmd_op`=3 (bit update) sends 0x05, `cmd_addr`, `cmd_mask`, `cmd_wdata` in that order.
- R10: `done` is a one-cycle pulse on the edge where `spi_cs_n` rises. The frame keeps `spi_cs_n` low for exactly the sum of its low and high intervals plus the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 write, 1 read, 2 transmit request, 3 bit update |
| cmd_addr | input | 8 | Register address byte |
| cmd_wdata | input | 8 | Write data / transmit-request selector |
| cmd_mask | input | 8 | Mask byte for bit update |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte received by a read |
| spi_cs_n | output | 1 | Active-low select |
| spi_sck | output | 1 | Serial clock |
| spi_sdio_out | output | 1 | Value driven onto the shared data wire |
| spi_sdio_oe | output | 1 | Drive enable for the shared data wire |
| spi_sdio_in | input | 1 | Value sampled from the shared data wire |

## Verification
Every phase boundary is registered, so each clock-low and clock-high interval is an exact number of core cycles. The bench counts those intervals sample by sample at the falling core edge and compares each one with the length the bit value calls for. The frame length is predicted from the number of ones and zeros in the expected byte stream and checked against the count of cycles with `spi_cs_n` low. `done` is checked in the sample where `spi_cs_n` first reads high and checked clear one sample later. Read data is compared on that same sample. The bench-side peripheral drives each read bit while the clock is high, well before the next rising edge, so the synchroniser delay never moves a sample point.

// File: rtl/tw3_spi_pkg.sv
package tw3_spi_pkg;
   localparam int BYTE_W       = 8;
   localparam int MAX_TX_BYTES = 4;
   localparam int BIDX_W       = $clog2(MAX_TX_BYTES);
   localparam int TXC_W        = $clog2(MAX_TX_BYTES + 1);
   localparam int BIT_W        = $clog2(BYTE_W);

   typedef enum logic [1:0] {
      OP_WRITE  = 2'd0,
      OP_READ   = 2'd1,
      OP_RTS    = 2'd2,
      OP_BITMOD = 2'd3
   } tw3_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_TAIL
   } tw3_state_e;

   typedef struct packed {
      tw3_op_e             op;
      logic [BYTE_W-1:0]   addr;
      logic [BYTE_W-1:0]   wdata;
      logic [BYTE_W-1:0]   mask;
   } tw3_cmd_t;

   function automatic logic [TXC_W-1:0] tx_count(tw3_op_e op);
      case (op)
         OP_WRITE:  return TXC_W'(3);
         OP_READ:   return TXC_W'(2);
         OP_RTS:    return TXC_W'(1);
         default:   return TXC_W'(4);
      endcase
   endfunction
endpackage

// File: rtl/tw3_phase_timer.sv
module tw3_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/tw3_shifter.sv
module tw3_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift_out,
   input  logic         shift_in,
   input  logic         sin,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= '0;
      else if (load)       q <= load_val;
      else if (shift_in)   q <= {q[W-2:0], sin};
      else if (shift_out)  q <= {q[W-2:0], 1'b0};
   end
endmodule

// File: rtl/tw3_in_sync.sv
module tw3_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES == 0) begin : g_direct
      assign dout = din;
   end else begin : g_flops
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], din} & {STAGES{1'b1}};
      end
      assign dout = sync_q[STAGES-1];
   end
endmodule

// File: rtl/tw3_frame_builder.sv
module tw3_frame_builder
   import tw3_spi_pkg::*;
#(
   parameter logic [BYTE_W-1:0] OPC_WRITE    = 8'h02,
   parameter logic [BYTE_W-1:0] OPC_READ     = 8'h03,
   parameter logic [BYTE_W-1:0] OPC_BITMOD   = 8'h05,
   parameter logic [BYTE_W-1:0] OPC_RTS_BASE = 8'h80,
   parameter int                RTS_SEL_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  tw3_cmd_t          cmd_in,
   input  logic [BIDX_W-1:0] byte_idx,
   output logic [BYTE_W-1:0] first_byte,
   output logic [BYTE_W-1:0] next_byte,
   output logic [TXC_W-1:0]  tx_bytes,
   output logic              is_read
);
   tw3_cmd_t          cmd_q;
   logic [BYTE_W-1:0] rts_in, rts_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cmd_q <= '0;
      else if (capture) cmd_q <= cmd_in;
   end

   if (RTS_SEL_W == 0) begin : g_rts_fixed
      assign rts_in = OPC_RTS_BASE;
      assign rts_q  = OPC_RTS_BASE;
   end else begin : g_rts_sel
      assign rts_in = OPC_RTS_BASE | BYTE_W'(cmd_in.wdata[RTS_SEL_W-1:0]);
      assign rts_q  = OPC_RTS_BASE | BYTE_W'(cmd_q.wdata[RTS_SEL_W-1:0]);
   end

   function automatic logic [BYTE_W-1:0] pick(tw3_cmd_t c, logic [BIDX_W-1:0] idx,
                                              logic [BYTE_W-1:0] rts_b);
      logic [BYTE_W-1:0] r;
      case (c.op)
         OP_WRITE:  r = (idx == 0) ? OPC_WRITE : (idx == 1) ? c.addr : c.wdata;
         OP_READ:   r = (idx == 0) ? OPC_READ : c.addr;
         OP_RTS:    r = rts_b;
         default: begin
            case (idx)
               2'd0:    r = OPC_BITMOD;
               2'd1:    r = c.addr;
               2'd2:    r = c.mask;
               default: r = c.wdata;
            endcase
         end
      endcase
      return r;
   endfunction

   assign first_byte = pick(cmd_in, '0, rts_in);
   assign next_byte  = pick(cmd_q, byte_idx + 1'b1, rts_q);
   assign tx_bytes   = tx_count(cmd_q.op);
   assign is_read    = (cmd_q.op == OP_READ);
endmodule

// File: rtl/tw3_sequencer.sv
module tw3_sequencer
   import tw3_spi_pkg::*;
#(
   parameter int LOW_CYC   = 10,
   parameter int HIGH0_CYC = 10,
   parameter int HIGH1_CYC = 12,
   parameter int CNT_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              tmr_expired,
   input  logic              din,
   input  logic [BYTE_W-1:0] sh_q,
   input  logic [BYTE_W-1:0] first_byte,
   input  logic [BYTE_W-1:0] next_byte,
   input  logic [TXC_W-1:0]  tx_bytes,
   input  logic              is_read,
   output logic              capture,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output logic              sh_load,
   output logic [BYTE_W-1:0] sh_val,
   output logic              sh_shift_out,
   output logic              sh_shift_in,
   output logic [BIDX_W-1:0] byte_idx,
   output logic              cs_n,
   output logic              sck,
   output logic              oe,
   output logic              rx_active,
   output logic              done,
   output logic              busy,
   output logic [BYTE_W-1:0] rd_data
);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

   tw3_state_e        st_q, st_n;
   logic              cs_q, cs_n_n, sck_q, sck_n, oe_q, oe_n, rx_q, rx_n, done_q, done_n;
   logic [BIT_W-1:0]  bit_q, bit_n;
   logic [BIDX_W-1:0] bidx_q, bidx_n;
   logic [BYTE_W-1:0] rd_q, rd_n;
   logic              hb;

   always_comb begin
      st_n = st_q;  cs_n_n = cs_q;  sck_n = sck_q;  oe_n = oe_q;  rx_n = rx_q;
      bit_n = bit_q;  bidx_n = bidx_q;  rd_n = rd_q;  done_n = 1'b0;  hb = 1'b0;
      capture = 1'b0;  tmr_load = 1'b0;  tmr_val = CNT_W'(LOW_CYC - 1);
      sh_load = 1'b0;  sh_val = first_byte;  sh_shift_out = 1'b0;  sh_shift_in = 1'b0;
      case (st_q)
         ST_IDLE: if (cmd_valid) begin
            capture = 1'b1;  sh_load = 1'b1;  tmr_load = 1'b1;
            cs_n_n = 1'b0;  bit_n = BIT_LAST;  bidx_n = '0;  rx_n = 1'b0;
            st_n = ST_LOW;
         end
         ST_LOW: if (tmr_expired) begin
            sck_n = 1'b1;  st_n = ST_HIGH;  tmr_load = 1'b1;
            if (rx_q) begin
               sh_shift_in = 1'b1;
               hb = din;
            end else begin
               hb = sh_q[BYTE_W-1];
            end
            tmr_val = hb ? CNT_W'(HIGH1_CYC - 1) : CNT_W'(HIGH0_CYC - 1);
         end
         ST_HIGH: if (tmr_expired) begin
            sck_n = 1'b0;  tmr_load = 1'b1;  st_n = ST_LOW;
            if (bit_q != '0) begin
               bit_n = bit_q - 1'b1;
               sh_shift_out = !rx_q;
            end else if (!rx_q && (({1'b0, bidx_q} + 1'b1) < tx_bytes)) begin
               bidx_n = bidx_q + 1'b1;
               sh_load = 1'b1;  sh_val = next_byte;  bit_n = BIT_LAST;
            end else if (!rx_q && is_read) begin
               rx_n = 1'b1;  oe_n = 1'b0;  bit_n = BIT_LAST;
            end else begin
               st_n = ST_TAIL;
            end
         end
         ST_TAIL: if (tmr_expired) begin
            cs_n_n = 1'b1;  oe_n = 1'b1;  done_n = 1'b1;  st_n = ST_IDLE;
            if (rx_q) rd_n = sh_q;
            rx_n = 1'b0;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;  cs_q <= 1'b1;  sck_q <= 1'b0;  oe_q <= 1'b1;  rx_q <= 1'b0;
         bit_q <= '0;  bidx_q <= '0;  rd_q <= '0;  done_q <= 1'b0;
      end else begin
         st_q <= st_n;  cs_q <= cs_n_n;  sck_q <= sck_n;  oe_q <= oe_n;  rx_q <= rx_n;
         bit_q <= bit_n;  bidx_q <= bidx_n;  rd_q <= rd_n;  done_q <= done_n;
      end
   end

   assign byte_idx  = bidx_q;
   assign cs_n      = cs_q;
   assign sck       = sck_q;
   assign oe        = oe_q;
   assign rx_active = rx_q;
   assign done      = done_q;
   assign busy      = (st_q != ST_IDLE);
   assign rd_data   = rd_q;
endmodule

// File: rtl/tw3_spi_master.sv
module tw3_spi_master
   import tw3_spi_pkg::*;
#(
   parameter int                UNIT_CYCLES    = 2,
   parameter int                LOW_UNITS      = 5,
   parameter int                HIGH0_UNITS    = 5,
   parameter int                HIGH1_UNITS    = 6,
   parameter int                IN_SYNC_STAGES = 2,
   parameter int                RTS_SEL_W      = 3,
   parameter logic [7:0]        OPC_WRITE      = 8'h02,
   parameter logic [7:0]        OPC_READ       = 8'h03,
   parameter logic [7:0]        OPC_BITMOD     = 8'h05,
   parameter logic [7:0]        OPC_RTS_BASE   = 8'h80
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   input  logic [7:0] cmd_addr,
   input  logic [7:0] cmd_wdata,
   input  logic [7:0] cmd_mask,
   output logic       busy,
   output logic       done,
   output logic [7:0] rd_data,
   output logic       spi_cs_n,
   output logic       spi_sck,
   output logic       spi_sdio_out,
   output logic       spi_sdio_oe,
   input  logic       spi_sdio_in
);
   localparam int LOW_CYC   = LOW_UNITS   * UNIT_CYCLES;
   localparam int HIGH0_CYC = HIGH0_UNITS * UNIT_CYCLES;
   localparam int HIGH1_CYC = HIGH1_UNITS * UNIT_CYCLES;
   localparam int MAX_CYC   = (LOW_CYC > HIGH1_CYC) ? LOW_CYC : HIGH1_CYC;
   localparam int CNT_W     = $clog2(MAX_CYC) + 1;

   if (UNIT_CYCLES < 1 || LOW_UNITS < 1 || HIGH0_UNITS < 1) begin : g_bad_timing
      $error("tw3_spi_master: phase lengths must be at least one unit");
   end
   if (HIGH1_UNITS < HIGH0_UNITS) begin : g_bad_high
      $error("tw3_spi_master: high phase for a one must not be shorter than for a zero");
   end
   if (LOW_CYC <= IN_SYNC_STAGES) begin : g_bad_sync
      $error("tw3_spi_master: synchroniser delay must fit inside the low phase");
   end
   if (RTS_SEL_W < 0 || RTS_SEL_W > BYTE_W - 1) begin : g_bad_sel
      $error("tw3_spi_master: transmit-request selector width out of range");
   end

   tw3_cmd_t          cmd_in;
   logic              capture, tmr_load, tmr_expired, sh_load, sh_shift_out, sh_shift_in;
   logic              din, is_read, oe, rx_active;
   logic [CNT_W-1:0]  tmr_val;
   logic [BYTE_W-1:0] sh_val, sh_q, first_byte, next_byte;
   logic [TXC_W-1:0]  tx_bytes;
   logic [BIDX_W-1:0] byte_idx;

   assign cmd_in = '{op: tw3_op_e'(cmd_op), addr: cmd_addr, wdata: cmd_wdata, mask: cmd_mask};

   tw3_in_sync #(.STAGES(IN_SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(spi_sdio_in), .dout(din));

   tw3_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired));

   tw3_shifter #(.W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
      .shift_out(sh_shift_out), .shift_in(sh_shift_in), .sin(din), .q(sh_q));

   tw3_frame_builder #(
      .OPC_WRITE(OPC_WRITE), .OPC_READ(OPC_READ), .OPC_BITMOD(OPC_BITMOD),
      .OPC_RTS_BASE(OPC_RTS_BASE), .RTS_SEL_W(RTS_SEL_W)
   ) u_build (
      .clk(clk), .rst_n(rst_n), .capture(capture), .cmd_in(cmd_in), .byte_idx(byte_idx),
      .first_byte(first_byte), .next_byte(next_byte), .tx_bytes(tx_bytes), .is_read(is_read));

   tw3_sequencer #(
      .LOW_CYC(LOW_CYC), .HIGH0_CYC(HIGH0_CYC), .HIGH1_CYC(HIGH1_CYC), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .tmr_expired(tmr_expired), .din(din),
      .sh_q(sh_q), .first_byte(first_byte), .next_byte(next_byte), .tx_bytes(tx_bytes),
      .is_read(is_read), .capture(capture), .tmr_load(tmr_load), .tmr_val(tmr_val),
      .sh_load(sh_load), .sh_val(sh_val), .sh_shift_out(sh_shift_out),
      .sh_shift_in(sh_shift_in), .byte_idx(byte_idx), .cs_n(spi_cs_n), .sck(spi_sck),
      .oe(oe), .rx_active(rx_active), .done(done), .busy(busy), .rd_data(rd_data));

   assign spi_sdio_oe  = oe;
   assign spi_sdio_out = sh_q[BYTE_W-1] & oe & ~spi_cs_n & ~rx_active;
endmodule

// File: rtl/tw3_spi_master_chk.sv
module tw3_spi_master_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic busy,
   input logic done,
   input logic spi_cs_n,
   input logic spi_sck,
   input logic spi_sdio_out,
   input logic spi_sdio_oe
);
   // R1: idle pins whenever select is high
   assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> (!spi_sck && !spi_sdio_out && spi_sdio_oe));

   // R2: select low implies a command is in progress
   assert_busy_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> busy);

   // R2: a frame starts only from idle with a request present
   assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (!$past(busy) && $past(cmd_valid)));

   // R3: wire holds steady while the clock stays high
   assert_data_stable_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_sdio_out));

   // R7: drive enable comes back only as select rises
   assert_oe_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sdio_oe) |-> $rose(spi_cs_n));

   // R10: completion pulse coincides with the select rising
   assert_done_with_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(spi_cs_n));

   assert_cs_rise_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> done);
endmodule

bind tw3_spi_master tw3_spi_master_chk u_chk (.*);

// File: tb/tw3_spi_master_bench.sv
module tw3_spi_master_bench;
   localparam int U = 2, L = 5, H0 = 5, H1 = 6;
   localparam int WD_CYCLES = 150000;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = '0;
   logic [7:0] cmd_addr = '0, cmd_wdata = '0, cmd_mask = '0;
   logic       busy, done, spi_cs_n, spi_sck, spi_sdio_out, spi_sdio_oe, sdio_in_w;
   logic [7:0] rd_data;

   int checks = 0, failures = 0;

   // monitor state
   int          mon_frames = 0, mon_ntx = 0, mon_flen = 0, mon_lerr = 0, mon_herr = 0;
   int          mon_lowrun = 0, mon_highrun = 0, mon_oe_bad = 0, mon_idle_bad = 0;
   logic [3:0]  mon_nrx = '0;
   logic [31:0] mon_txall = '0;
   logic [7:0]  rd_byte = '0, rd_cur = '0;
   logic        prev_sck = 1'b0, prev_cs = 1'b1, cur_bit = 1'b0;

   always #2ns clk = ~clk;

   assign sdio_in_w = (!spi_sdio_oe && !spi_cs_n) ? rd_cur[7] : 1'b0;

   tw3_spi_master #(.UNIT_CYCLES(U), .LOW_UNITS(L), .HIGH0_UNITS(H0), .HIGH1_UNITS(H1))
   u_tw3_spi_master (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask), .busy(busy), .done(done), .rd_data(rd_data),
      .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_sdio_out(spi_sdio_out),
      .spi_sdio_oe(spi_sdio_oe), .spi_sdio_in(sdio_in_w));

   // peripheral model and phase-length monitor (R3, R4, R5, R7)
   always @(negedge clk) begin
      if (rst_n) begin
         if (!spi_cs_n) begin
            if (prev_cs) begin
               mon_frames++;  mon_ntx = 0;  mon_nrx = '0;  mon_txall = '0;  mon_flen = 0;
               mon_lowrun = 0;  mon_highrun = 0;  rd_cur = rd_byte;
            end
            mon_flen++;
            if (spi_sck) begin
               if (!prev_sck) begin
                  if (mon_lowrun != L*U) mon_lerr++;
                  mon_lowrun = 0;
                  if (spi_sdio_oe) begin
                     cur_bit = spi_sdio_out;
                     mon_txall = {mon_txall[30:0], spi_sdio_out};
                     mon_ntx++;
                     if (mon_nrx != 0) mon_oe_bad++;
                  end else begin
                     cur_bit = rd_cur[7];
                     rd_cur = {rd_cur[6:0], 1'b0};
                     mon_nrx = mon_nrx + 1'b1;
                  end
               end
               mon_highrun++;
            end else begin
               if (prev_sck) begin
                  if (mon_highrun != (cur_bit ? H1 : H0) * U) mon_herr++;
                  mon_highrun = 0;
               end
               mon_lowrun++;
            end
         end else begin
            if (!prev_cs && mon_lowrun != L*U) mon_lerr++;
            if (spi_sck || spi_sdio_out || !spi_sdio_oe) mon_idle_bad++;
         end
         prev_sck = spi_sck;
         prev_cs  = spi_cs_n;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // op, addr, wdata, mask, read value
   localparam logic [33:0] VEC [8] = '{
      {2'd0, 8'h2A, 8'hC3, 8'h00, 8'h00},
      {2'd0, 8'h00, 8'hFF, 8'h00, 8'h00},
      {2'd1, 8'h31, 8'h00, 8'h00, 8'hA5},
      {2'd1, 8'h0F, 8'h00, 8'h00, 8'h00},
      {2'd1, 8'hF0, 8'h00, 8'h00, 8'hFF},
      {2'd2, 8'h00, 8'h05, 8'h00, 8'h00},
      {2'd2, 8'h00, 8'hFA, 8'h00, 8'h00},
      {2'd3, 8'h2C, 8'h5A, 8'h0F, 8'h00}
   };

   task automatic run_cmd(input logic [1:0] op, input logic [7:0] a, input logic [7:0] w,
                          input logic [7:0] m, input logic [7:0] r, input int inject_at);
      logic [31:0] exp_all;
      logic [7:0]  rd_before;
      int n, ones, exp_len, fr0, t;
      string tag;
      case (op)
         2'd0: begin exp_all = {8'h00, 8'h02, a, w}; n = 3; tag = "R6"; end
         2'd1: begin exp_all = {16'h0000, 8'h03, a};  n = 2; tag = "R7"; end
         2'd2: begin exp_all = {24'h0, 8'h80 | {5'b0, w[2:0]}}; n = 1; tag = "R8"; end
         default: begin exp_all = {8'h05, a, m, w}; n = 4; tag = "R9"; end
      endcase
      ones = $countones(exp_all);
      exp_len = (L*n*8 + H1*ones + H0*(n*8 - ones)) * U + L*U;
      if (op == 2'd1)
         exp_len += (L*8 + H1*$countones(r) + H0*(8 - $countones(r))) * U;
      rd_byte = r;  rd_before = rd_data;  fr0 = mon_frames;
      @(negedge clk);
      cmd_op = op;  cmd_addr = a;  cmd_wdata = w;  cmd_mask = m;  cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
      t = 0;
      while (!done && t < 20000) begin
         @(negedge clk);
         t++;
         if (inject_at != 0 && t == inject_at) begin
            cmd_op = 2'd1;  cmd_addr = 8'h77;  cmd_wdata = 8'h11;  cmd_valid = 1'b1;
         end else begin
            cmd_valid = 1'b0;
         end
      end
      cmd_valid = 1'b0;
      chk(done == 1'b1, "R10 done seen", 32'(done), 32'd1);
      chk(spi_cs_n == 1'b1, "R10 select high with done", 32'(spi_cs_n), 32'd1);
      chk(mon_frames == fr0 + 1, "R2 one frame per command", 32'(mon_frames), 32'(fr0 + 1));
      chk(mon_ntx == n*8, {tag, " sent bit count"}, 32'(mon_ntx), 32'(n*8));
      chk(mon_txall == exp_all, {tag, " R3 byte stream msb first"}, mon_txall, exp_all);
      chk(mon_lerr == 0, "R4 low phase length", 32'(mon_lerr), 32'd0);
      chk(mon_herr == 0, "R5 high phase length", 32'(mon_herr), 32'd0);
      chk(mon_flen == exp_len, "R10 frame length", 32'(mon_flen), 32'(exp_len));
      if (op == 2'd1) begin
         chk(mon_nrx == 4'd8, "R7 received bit count", 32'(mon_nrx), 32'd8);
         chk(rd_data == r, "R7 read data", 32'(rd_data), 32'(r));
         chk(mon_oe_bad == 0, "R7 drive stays off in receive", 32'(mon_oe_bad), 32'd0);
      end else begin
         chk(mon_nrx == 4'd0, {tag, " no receive phase"}, 32'(mon_nrx), 32'd0);
         chk(rd_data == rd_before, "R7 rd_data held", 32'(rd_data), 32'(rd_before));
      end
      @(negedge clk);
      chk(done == 1'b0, "R10 done one cycle", 32'(done), 32'd0);
      mon_lerr = 0;  mon_herr = 0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(spi_cs_n == 1'b1, "R1 reset select", 32'(spi_cs_n), 32'd1);
      chk(spi_sck == 1'b0, "R1 reset clock", 32'(spi_sck), 32'd0);
      chk(spi_sdio_out == 1'b0, "R1 reset data", 32'(spi_sdio_out), 32'd0);
      chk(spi_sdio_oe == 1'b1, "R1 reset drive enable", 32'(spi_sdio_oe), 32'd1);
      chk(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", {30'd0, busy, done}, 32'd0);
      chk(rd_data == 8'h00, "R1 reset rd_data", 32'(rd_data), 32'd0);

      for (int i = 0; i < 8; i++) begin
         run_cmd(VEC[i][33:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 0);
      end

      // R2: request raised mid-frame must be ignored
      run_cmd(2'd0, 8'h5E, 8'h81, 8'h00, 8'h00, 60);
      repeat (40) @(negedge clk);
      chk(spi_cs_n == 1'b1 && busy == 1'b0, "R2 no frame from ignored request",
          {30'd0, spi_cs_n, busy}, 32'd2);
      chk(rd_data == 8'hFF, "R2 ignored read left rd_data", 32'(rd_data), 32'hFF);

      // back-to-back: read right after a bit update
      run_cmd(2'd3, 8'h00, 8'h00, 8'hFF, 8'h00, 0);
      run_cmd(2'd1, 8'hFF, 8'h00, 8'h00, 8'h3C, 0);

      chk(mon_idle_bad == 0, "R1 idle pins between frames", 32'(mon_idle_bad), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      $display("FAIL watchdog expired act=%0d exp=0", WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
   end
endmodule